// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the general-purpose register file of a 32-bit load/store processor whose procedures each see 32 logical registers. Those logical registers are mapped onto a physical array of 138 entries: ten registers shared by every procedure, plus a ring of eight windows. A current-window pointer selects the active window. A call strobe advances the pointer and a return strobe moves it back. Each window's outgoing-argument group is physically the same storage as the next window's incoming-argument group. A caller therefore hands parameters to its callee, and receives results back, without copying any data.

The block has two combinational read ports and one write port that takes effect at the rising clock edge. It also tracks how many windows are resident. If a call would reuse the storage of the oldest live window, it raises a one-cycle overflow flag. If a return would go below the bottom live window, it raises a one-cycle underflow flag. The pointer moves in both of these cases. Spilling windows to memory is the job of the surrounding trap logic.

Logical layout: registers 0..9 are shared, 10..15 are the outgoing group, 16..25 are private locals, and 26..31 are the incoming group.

Top module: `rwin_regfile`

## Requirements
- R1: Logical registers 1..9 address the same storage in every window: a value written to one of them in any window reads back unchanged in every other window.
- R2: Logical register 0 always reads as zero on both read ports, and a write addressed to it has no effect.
- R3: Reset sets the window pointer to 0. A call alone advances it by one, wrapping from 7 to 0. A return alone moves it back by one, wrapping from 0 to 7. Call and return asserted together, or neither asserted, leave it unchanged.
- R4: Logical registers 10..15 of window w are the same storage as logical registers 26..31 of window (w+1) mod 8, in both directions and across the 7-to-0 wrap.
- R5: Logical registers 16..25 are private to their window: a write to one of them in one window does not change the value read at that address in any other window.
- R6: A write presented in the same cycle as a call or a return goes into the window that was current before that edge.
- R7: Both read ports are combinational and independent. A value written at an edge can be read on either port in the following cycle, in the current window.
- R8: The resident depth starts at 0. A call at depth 7 sets the overflow flag high for exactly the next cycle, and the depth stays at 7. Any other call increments the depth.
- R9: A return at depth 0 sets the underflow flag high for exactly the next cycle, and the depth stays at 0. Any other return decrements the depth. The pointer moves in both cases.
- R10: Reset clears the pointer, the depth and both flags. It leaves the register contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| ra_addr_i | input | 5 | Read port A logical address |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 5 | Read port B logical address |
| rb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write logical address |
| wr_data_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | Window overflow, one-cycle pulse |
| unf_o | output | 1 | Window underflow, one-cycle pulse |

## Verification
Read data is due in the same cycle that its address is driven, so each cycle the bench compares both read ports one nanosecond after the falling edge, once its inputs have settled. A write, a pointer move and a flag are all due one rising edge after their stimulus. The behavioural model therefore commits each cycle's write, event and flag predictions at that edge, using the pointer value from before the edge, and the next cycle's sample checks them. Read ports are compared only for addresses whose contents the model knows, and the window pointer and both flags are compared on every cycle.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  typedef enum logic [1:0] {
    WEV_IDLE = 2'd0,
    WEV_CALL = 2'd1,
    WEV_RET  = 2'd2
  } win_ev_e;

  // Call and return together cancel out.
  function automatic win_ev_e decode_ev(input logic call, input logic ret);
    if (call && !ret) return WEV_CALL;
    if (ret && !call) return WEV_RET;
    return WEV_IDLE;
  endfunction

endpackage

// File: rtl/rwf_map.sv
module rwf_map #(
  parameter int N_WIN    = 8,
  parameter int N_GLOBAL = 10,
  parameter int N_SHARE  = 6,
  parameter int N_LOCAL  = 10,
  parameter int LA_W     = 5,
  parameter int PA_W     = 8,
  parameter int PTR_W    = 3
) (
  input  logic [LA_W-1:0]  la_i,
  input  logic [PTR_W-1:0] cwp_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             zero_o
);
  localparam int LOW_B  = N_GLOBAL;
  localparam int LOC_B  = N_GLOBAL + N_SHARE;
  localparam int HIGH_B = LOC_B + N_LOCAL;
  localparam int STRIDE = N_LOCAL + N_SHARE;

  int lv, cw, pw, idx;

  always_comb begin
    lv = int'(la_i);
    cw = int'(cwp_i);
    pw = (cw == 0) ? N_WIN - 1 : cw - 1;
    if (lv < LOW_B)
      idx = lv;
    else if (lv < LOC_B)
      idx = N_GLOBAL + cw * STRIDE + N_LOCAL + (lv - LOW_B);
    else if (lv < HIGH_B)
      idx = N_GLOBAL + cw * STRIDE + (lv - LOC_B);
    else
      idx = N_GLOBAL + pw * STRIDE + N_LOCAL + (lv - HIGH_B);
  end

  assign pa_o   = PA_W'(idx);
  assign zero_o = (la_i == '0);

endmodule

// File: rtl/rwf_store.sv
module rwf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 138,
  parameter int PA_W   = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PA_W-1:0]   wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [PA_W-1:0]   ra_a_i,
  output logic [DATA_W-1:0] rd_a_o,
  input  logic [PA_W-1:0]   ra_b_i,
  output logic [DATA_W-1:0] rd_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  assign rd_a_o = mem[ra_a_i];
  assign rd_b_o = mem[ra_b_i];

endmodule

// File: rtl/rwf_window_ctrl.sv
module rwf_window_ctrl
  import rwf_pkg::*;
#(
  parameter int N_WIN = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [PTR_W-1:0] cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [PTR_W-1:0] TOP_PTR   = PTR_W'(N_WIN - 1);
  localparam logic [PTR_W-1:0] MAX_DEPTH = PTR_W'(N_WIN - 1);

  win_ev_e          ev;
  logic [PTR_W-1:0] cwp_q, depth_q, cwp_inc, cwp_dec;
  logic             ovf_q, unf_q;

  assign ev      = decode_ev(call_i, ret_i);
  assign cwp_inc = (cwp_q == TOP_PTR) ? '0 : cwp_q + 1'b1;
  assign cwp_dec = (cwp_q == '0) ? TOP_PTR : cwp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q   <= '0;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      case (ev)
        WEV_CALL: begin
          cwp_q <= cwp_inc;
          if (depth_q == MAX_DEPTH) ovf_q <= 1'b1;
          else depth_q <= depth_q + 1'b1;
        end
        WEV_RET: begin
          cwp_q <= cwp_dec;
          if (depth_q == '0) unf_q <= 1'b1;
          else depth_q <= depth_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cwp_o = cwp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  AST_CALL_STEP: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i) |=> (cwp_q == (($past(cwp_q) == TOP_PTR) ? '0 : $past(cwp_q) + 1'b1))); // R3
  AST_RET_STEP: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i) |=> (cwp_q == (($past(cwp_q) == '0) ? TOP_PTR : $past(cwp_q) - 1'b1))); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (call_i == ret_i) |=> $stable(cwp_q)); // R3
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && depth_q == MAX_DEPTH) |=> (ovf_q && $stable(depth_q))); // R8
  AST_OVF_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
    !(call_i && !ret_i) |=> !ovf_q); // R8
  AST_UNF_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && depth_q == '0) |=> (unf_q && depth_q == '0)); // R9
  AST_UNF_ONLY_RET: assert property (@(posedge clk) disable iff (rst)
    !(ret_i && !call_i) |=> !unf_q); // R9
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf_q && unf_q)); // R8

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile #(
  parameter int DATA_W   = 32,
  parameter int N_WIN    = 8,
  parameter int N_GLOBAL = 10,
  parameter int N_SHARE  = 6,
  parameter int N_LOCAL  = 10,
  localparam int N_LOG   = N_GLOBAL + 2 * N_SHARE + N_LOCAL,
  localparam int LA_W    = $clog2(N_LOG),
  localparam int PTR_W   = $clog2(N_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [LA_W-1:0]   ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [LA_W-1:0]   rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              wr_en_i,
  input  logic [LA_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PTR_W-1:0]  cwp_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int STRIDE  = N_LOCAL + N_SHARE;
  localparam int N_PHYS  = N_GLOBAL + N_WIN * STRIDE;
  localparam int PA_W    = $clog2(N_PHYS);
  localparam int N_PORTS = 3;   // 0: read A, 1: read B, 2: write

  logic [PTR_W-1:0]  cwp;
  logic [LA_W-1:0]   la_v   [N_PORTS];
  logic [PA_W-1:0]   pa_v   [N_PORTS];
  logic              zero_v [N_PORTS];
  logic [DATA_W-1:0] mem_a, mem_b;
  logic              mem_we;

  rwf_window_ctrl #(.N_WIN(N_WIN), .PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .cwp_o(cwp), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  assign la_v[0] = ra_addr_i;
  assign la_v[1] = rb_addr_i;
  assign la_v[2] = wr_addr_i;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_map
    rwf_map #(
      .N_WIN(N_WIN), .N_GLOBAL(N_GLOBAL), .N_SHARE(N_SHARE), .N_LOCAL(N_LOCAL),
      .LA_W(LA_W), .PA_W(PA_W), .PTR_W(PTR_W)
    ) map_i (
      .la_i(la_v[p]), .cwp_i(cwp), .pa_o(pa_v[p]), .zero_o(zero_v[p])
    );
  end

  assign mem_we = wr_en_i && !zero_v[2];

  rwf_store #(.DATA_W(DATA_W), .DEPTH(N_PHYS), .PA_W(PA_W)) store_i (
    .clk(clk), .we_i(mem_we), .wa_i(pa_v[2]), .wd_i(wr_data_i),
    .ra_a_i(pa_v[0]), .rd_a_o(mem_a), .ra_b_i(pa_v[1]), .rd_b_o(mem_b)
  );

  assign ra_data_o = zero_v[0] ? '0 : mem_a;
  assign rb_data_o = zero_v[1] ? '0 : mem_b;
  assign cwp_o     = cwp;

  AST_ZERO_PORT_A: assert property (@(posedge clk) disable iff (rst)
    (ra_addr_i == '0) |-> (ra_data_o == '0)); // R2
  AST_ZERO_PORT_B: assert property (@(posedge clk) disable iff (rst)
    (rb_addr_i == '0) |-> (rb_data_o == '0)); // R2
  AST_SAME_ADDR_SAME_DATA: assert property (@(posedge clk) disable iff (rst)
    (ra_addr_i == rb_addr_i) |-> (ra_data_o == rb_data_o)); // R7

endmodule

// File: tb/rwin_regfile_tb_top.sv
module rwin_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_i = 0, ret_i = 0, wr_en_i = 0;
  logic [4:0]  ra_addr_i = 0, rb_addr_i = 0, wr_addr_i = 0;
  logic [31:0] wr_data_i = 0;
  logic [31:0] ra_data_o, rb_data_o;
  logic [2:0]  cwp_o;
  logic        ovf_o, unf_o;

  always #2 clk = ~clk;

  rwin_regfile dut_i (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .ra_addr_i(ra_addr_i), .ra_data_o(ra_data_o),
    .rb_addr_i(rb_addr_i), .rb_data_o(rb_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // Behavioural model: per-window groups, incoming group borrowed from the caller.
  logic [31:0] m_glb [10];  bit m_glb_v [10];
  logic [31:0] m_loc [8][10]; bit m_loc_v [8][10];
  logic [31:0] m_out [8][6];  bit m_out_v [8][6];
  int m_cwp = 0, m_depth = 0;
  bit m_ovf = 0, m_unf = 0;
  int vectors = 0, fails = 0;
  bit done = 0;

  function automatic void m_read(input int la, input int w, output logic [31:0] d, output bit ok);
    if (la == 0) begin d = 0; ok = 1; end
    else if (la < 10) begin d = m_glb[la]; ok = m_glb_v[la]; end
    else if (la < 16) begin d = m_out[w][la-10]; ok = m_out_v[w][la-10]; end
    else if (la < 26) begin d = m_loc[w][la-16]; ok = m_loc_v[w][la-16]; end
    else begin d = m_out[(w+7)%8][la-26]; ok = m_out_v[(w+7)%8][la-26]; end
  endfunction

  function automatic void m_write(input int la, input int w, input logic [31:0] d);
    if (la == 0) return;
    else if (la < 10) begin m_glb[la] = d; m_glb_v[la] = 1; end
    else if (la < 16) begin m_out[w][la-10] = d; m_out_v[w][la-10] = 1; end
    else if (la < 26) begin m_loc[w][la-16] = d; m_loc_v[w][la-16] = 1; end
    else begin m_out[(w+7)%8][la-26] = d; m_out_v[(w+7)%8][la-26] = 1; end
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d; bit ok;
    cmp(tag, "cwp", 32'(cwp_o), 32'(m_cwp));
    cmp(tag, "ovf", 32'(ovf_o), 32'(m_ovf));
    cmp(tag, "unf", 32'(unf_o), 32'(m_unf));
    m_read(int'(ra_addr_i), m_cwp, d, ok);
    if (ok) cmp(tag, "port A", ra_data_o, d);
    m_read(int'(rb_addr_i), m_cwp, d, ok);
    if (ok) cmp(tag, "port B", rb_data_o, d);
  endtask

  task automatic cyc(input bit c, input bit r, input bit w, input int wa, input logic [31:0] wd,
                     input int aa, input int ab, input string tag);
    call_i = c; ret_i = r; wr_en_i = w;
    wr_addr_i = 5'(wa); wr_data_i = wd; ra_addr_i = 5'(aa); rb_addr_i = 5'(ab);
    #1;
    check_all(tag);
    @(posedge clk);
    if (w) m_write(wa, m_cwp, wd);
    m_ovf = 0; m_unf = 0;
    if (c && !r) begin
      if (m_depth == 7) m_ovf = 1; else m_depth++;
      m_cwp = (m_cwp + 1) % 8;
    end else if (r && !c) begin
      if (m_depth == 0) m_unf = 1; else m_depth--;
      m_cwp = (m_cwp + 7) % 8;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; call_i = 0; ret_i = 0; wr_en_i = 0;
    @(posedge clk);
    m_cwp = 0; m_depth = 0; m_ovf = 0; m_unf = 0;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10: reset state of pointer and flags
    cyc(0, 0, 0, 0, 0, 0, 0, "R10 reset state");

    // R2: write to register 0 is dropped
    cyc(0, 0, 1, 0, 32'hFFFF_FFFF, 0, 0, "R2 write r0");
    cyc(0, 0, 0, 0, 0, 0, 0, "R2 read r0");

    // R1: globals written in window 0, read in later windows
    for (int i = 1; i < 10; i++) cyc(0, 0, 1, i, 32'h1000 + i, i - 1, 0, "R1 fill globals");
    for (int k = 0; k < 3; k++) begin
      cyc(1, 0, 0, 0, 0, 1, 9, "R1 call");
      for (int i = 1; i < 10; i++) cyc(0, 0, 0, 0, 0, i, 10 - i, "R1 global read");
    end
    cyc(0, 0, 1, 5, 32'hABCD_0005, 5, 0, "R1 global write deep");
    cyc(0, 0, 0, 0, 0, 5, 5, "R7 read after write");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0, 0, 5, 4, "R1 return");
    cyc(0, 0, 0, 0, 0, 5, 9, "R1 global after return");

    // R4: outgoing group of caller appears as incoming group of callee
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 10 + i, 32'h2000 + i, 0, 0, "R4 caller out");
    cyc(1, 0, 0, 0, 0, 10, 15, "R4 call");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 26 + i, 31 - i, "R4 callee in");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 26 + i, 32'h3000 + i, 26 + i, 0, "R4 callee result");

    // R5: locals private to their window
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 16 + i, 32'h5100 + i, 0, 0, "R5 locals w1");
    cyc(0, 1, 0, 0, 0, 16, 17, "R5 return");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 10 + i, 15 - i, "R4 results in caller");
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 16 + i, 32'h5000 + i, 0, 0, "R5 locals w0");
    cyc(1, 0, 0, 0, 0, 16, 25, "R5 call");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 16 + i, 25 - i, "R5 locals w1 intact");
    cyc(0, 1, 0, 0, 0, 16, 25, "R5 return");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 16 + i, 25 - i, "R5 locals w0 intact");

    // R6: write in the same cycle as a call or return lands in the old window
    cyc(1, 0, 1, 20, 32'h6600_0000, 20, 0, "R6 write with call");
    cyc(0, 0, 0, 0, 0, 20, 0, "R6 new window local");
    cyc(0, 1, 1, 21, 32'h6611_0001, 21, 0, "R6 write with return");
    cyc(0, 0, 0, 0, 0, 20, 21, "R6 old window check");
    cyc(1, 0, 0, 0, 0, 21, 0, "R6 call again");
    cyc(0, 0, 0, 0, 0, 21, 20, "R6 write with return landed");
    cyc(0, 1, 0, 0, 0, 0, 0, "R6 back");

    // R3: simultaneous strobes hold the pointer
    cyc(1, 1, 0, 0, 0, 0, 0, "R3 call+ret");
    cyc(1, 1, 0, 0, 0, 0, 0, "R3 call+ret hold");

    // R8 / R4 wrap: chain of calls around the whole ring
    for (int i = 0; i < 11; i++) begin
      cyc(0, 0, 1, 10 + (i % 6), 32'h8000 + i, 16, 0, "R8 pre-call write");
      cyc(1, 0, 0, 0, 0, 10 + (i % 6), 3, "R8 call chain");
      cyc(0, 0, 0, 0, 0, 26 + (i % 6), 5, "R4 wrap incoming");
    end

    // R9: unwind past the bottom
    for (int i = 0; i < 11; i++) cyc(0, 1, 0, 0, 0, 7, 2, "R9 return chain");
    cyc(0, 1, 0, 0, 0, 1, 0, "R9 underflow again");
    cyc(0, 0, 0, 0, 0, 0, 0, "R9 flag clears");

    // R10: reset mid-run keeps contents
    cyc(1, 0, 0, 0, 0, 0, 0, "R10 move pointer");
    cyc(0, 0, 1, 22, 32'hBEEF_0022, 0, 0, "R10 write local");
    cyc(0, 1, 0, 0, 0, 22, 0, "R10 return to base");
    cyc(0, 0, 1, 8, 32'hBEEF_0008, 0, 0, "R10 write global");
    do_reset();
    cyc(0, 0, 0, 0, 0, 8, 1, "R10 contents after reset");
    cyc(1, 0, 0, 0, 0, 8, 0, "R10 call after reset");
    cyc(0, 0, 0, 0, 0, 22, 9, "R10 local after reset");
    cyc(0, 0, 0, 0, 0, 0, 0, "R7 idle");

    finish_run();
  end
endmodule